// File: doc/BRIEF.md
# Confirmation-cycle trigger controller

This block sits after a fast per-crossing trigger decision and decides whether an event is passed at once or held while slower confirmation logic reaches a verdict. It advances only on a master clock enable that pulses once per inter-crossing period. A confirmation cycle may open only on a tick that coincides with the crossing marker.

A cycle opens only if the fast decision shows confirm-capable triggers and no fast-only trigger. While the cycle runs, the block looks for a reason to let the event go. Any acceptance, or an expired tick budget, passes the event. A reject needs every confirm-capable trigger that fired at the opening crossing to have come back vetoed. The first two ticks after opening are blind to the confirmation inputs. A bypass input makes every fired crossing pass at once, so that no cycle can open.

Top module: `trig_cycle_ctrl`

## Requirements
- R1: On a tick with the crossing marker high and no cycle open, `fast_any_i` high gives a `pass_o` pulse one clock later and no cycle opens, even when `slow_any_i` is also high.
- R2: A cycle opens (`busy_o` rises one clock after the tick) only on a tick with the crossing marker high, `slow_any_i` high, `fast_any_i` low and `bypass_i` low. Without the marker nothing happens.
- R3: With `bypass_i` high, a tick with the crossing marker and either fired flag gives a `pass_o` pulse and no cycle opens.
- R4: `acc_any_i` and `veto_vec_i` are ignored on the first BLANK_TICKS (default 2) ticks after the opening tick.
- R5: After the blind window, a tick with `acc_any_i` high ends the cycle with a pass, even if some fired triggers are vetoed. `busy_o` falls in the same clock as the `pass_o` pulse.
- R6: `fired_vec_i` is latched at the opening tick. Bit i of `veto_vec_i` refers to bit i of that latched mask. A tick gives `reject_o` only when every latched bit has its veto bit set. Veto bits of triggers that did not fire have no effect.
- R7: If no verdict arrives, the TO_TICKS-th tick after the opening tick ends the cycle with `pass_o` and `timeout_o` pulsed together.
- R8: Acceptance wins over a complete veto set on the same tick. A verdict on the final tick wins over the timeout, so `timeout_o` stays low.
- R9: `pass_o`, `reject_o` and `timeout_o` are one-clock pulses. `pass_o` and `reject_o` are never high together. `timeout_o` is high only with `pass_o`.
- R10: After reset, `busy_o`, `pass_o`, `reject_o` and `timeout_o` are low.
- R11: In clocks without `tick_i`, no output pulses and `busy_o` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Master clock enable, one per inter-crossing period |
| xing_i | input | 1 | Crossing marker, qualified by tick_i |
| bypass_i | input | 1 | Pass every fired crossing at once and never open a cycle |
| fast_any_i | input | 1 | At least one fast-only trigger fired |
| slow_any_i | input | 1 | At least one confirm-capable trigger fired |
| fired_vec_i | input | N_TRIG | Per-trigger fired flags of the confirm-capable triggers |
| acc_any_i | input | 1 | At least one fired confirm-capable trigger confirmed |
| veto_vec_i | input | N_TRIG | Per-trigger veto flags |
| busy_o | output | 1 | Confirmation cycle in progress |
| pass_o | output | 1 | Event passed (pulse) |
| reject_o | output | 1 | Event rejected (pulse) |
| timeout_o | output | 1 | Pass was forced by the tick budget (pulse) |

## Verification
Two cases can fall on the same tick.

The first is an acceptance arriving on the tick that also completes the veto set. The bench provokes it by raising `acc_any_i` together with all veto bits, both while the block is blind and on the first tick after the blind window. The result is judged correct only if `pass_o` pulses and `reject_o` stays low.

The second is a verdict arriving on the tick where the budget runs out. The bench provokes it by holding off every verdict until that tick and then raising `acc_any_i`. The result is judged correct only if `pass_o` pulses and `timeout_o` stays low.

// File: rtl/trig_cycle_pkg.sv
package trig_cycle_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } cyc_st_e;
endpackage

// File: rtl/tcc_start_dec.sv
module tcc_start_dec (
  input  logic bypass_i,
  input  logic fast_any_i,
  input  logic slow_any_i,
  output logic go_pass_o,
  output logic go_start_o
);
  // fast-only reason wins; bypass turns any slow reason into a pass
  always_comb begin
    go_pass_o  = fast_any_i | (bypass_i & slow_any_i);
    go_start_o = slow_any_i & ~fast_any_i & ~bypass_i;
  end
endmodule

// File: rtl/tcc_term_eval.sv
module tcc_term_eval #(
  parameter int N_TRIG = 16
) (
  input  logic              live_i,
  input  logic              acc_any_i,
  input  logic [N_TRIG-1:0] mask_i,
  input  logic [N_TRIG-1:0] veto_vec_i,
  output logic              hit_acc_o,
  output logic              hit_rej_o
);
  logic [N_TRIG-1:0] pending;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_pend
    assign pending[g] = mask_i[g] & ~veto_vec_i[g];
  end

  always_comb begin
    hit_acc_o = live_i & acc_any_i;
    hit_rej_o = live_i & ~(|pending);
  end
endmodule

// File: rtl/tcc_timer.sv
module tcc_timer #(
  parameter int TO_TICKS    = 64,
  parameter int BLANK_TICKS = 2,
  localparam int CW = $clog2(TO_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic live_o,
  output logic expire_o
);
  localparam logic [CW-1:0] LAST  = CW'(TO_TICKS - 1);
  localparam logic [CW-1:0] BLANK = CW'(BLANK_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (step_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    live_o   = cnt_q >= BLANK;
    expire_o = cnt_q == LAST;
  end
endmodule

// File: rtl/trig_cycle_ctrl.sv
module trig_cycle_ctrl
  import trig_cycle_pkg::*;
#(
  parameter int N_TRIG      = 16,
  parameter int TO_TICKS    = 64,
  parameter int BLANK_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              xing_i,
  input  logic              bypass_i,
  input  logic              fast_any_i,
  input  logic              slow_any_i,
  input  logic [N_TRIG-1:0] fired_vec_i,
  input  logic              acc_any_i,
  input  logic [N_TRIG-1:0] veto_vec_i,
  output logic              busy_o,
  output logic              pass_o,
  output logic              reject_o,
  output logic              timeout_o
);
  cyc_st_e           st_q;
  logic [N_TRIG-1:0] mask_q;
  logic              pass_q, rej_q, to_q;
  logic              go_pass, go_start, live, expire, hit_acc, hit_rej;
  logic              open_now;

  assign open_now = tick_i && xing_i && (st_q == ST_IDLE) && go_start;

  tcc_start_dec u_start (
    .bypass_i  (bypass_i),
    .fast_any_i(fast_any_i),
    .slow_any_i(slow_any_i),
    .go_pass_o (go_pass),
    .go_start_o(go_start)
  );

  tcc_timer #(.TO_TICKS(TO_TICKS), .BLANK_TICKS(BLANK_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (open_now),
    .step_i  (tick_i && st_q == ST_BUSY),
    .live_o  (live),
    .expire_o(expire)
  );

  tcc_term_eval #(.N_TRIG(N_TRIG)) u_eval (
    .live_i    (live),
    .acc_any_i (acc_any_i),
    .mask_i    (mask_q),
    .veto_vec_i(veto_vec_i),
    .hit_acc_o (hit_acc),
    .hit_rej_o (hit_rej)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      pass_q <= 1'b0;
      rej_q  <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      pass_q <= 1'b0;
      rej_q  <= 1'b0;
      to_q   <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (xing_i && go_pass) begin
              pass_q <= 1'b1;
            end else if (open_now) begin
              st_q   <= ST_BUSY;
              mask_q <= fired_vec_i;
            end
          end
          ST_BUSY: begin
            // priority: accept, full veto, budget
            if (hit_acc) begin
              pass_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else if (hit_rej) begin
              rej_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else if (expire) begin
              pass_q <= 1'b1;
              to_q   <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o    = st_q == ST_BUSY;
  assign pass_o    = pass_q;
  assign reject_o  = rej_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/trig_cycle_chk.sv
module trig_cycle_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic xing_i,
  input logic fast_any_i,
  input logic busy_o,
  input logic pass_o,
  input logic reject_o,
  input logic timeout_o
);
  AST_PASS_REJ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && reject_o)); // R9
  AST_TO_WITH_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> pass_o); // R9
  AST_PASS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o); // R9
  AST_REJ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |=> !reject_o); // R9
  AST_FAST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && xing_i && fast_any_i && !busy_o) |=> (pass_o && !busy_o)); // R1
  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (pass_o || reject_o)); // R5
  AST_REJ_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reject_o) |-> $fell(busy_o)); // R6
  AST_HOLD_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (!pass_o && !reject_o && $stable(busy_o))); // R11
endmodule

bind trig_cycle_ctrl trig_cycle_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .xing_i    (xing_i),
  .fast_any_i(fast_any_i),
  .busy_o    (busy_o),
  .pass_o    (pass_o),
  .reject_o  (reject_o),
  .timeout_o (timeout_o)
);

// File: tb/trig_cycle_ctrl_test.sv
module trig_cycle_ctrl_test;
  localparam int N  = 4;
  localparam int TO = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, xing = 0, bypass = 0, fast = 0, slow = 0, acc = 0;
  logic [N-1:0] fired = '0, veto = '0;
  logic busy, pass, rej, tmo;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  trig_cycle_ctrl #(.N_TRIG(N), .TO_TICKS(TO), .BLANK_TICKS(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .xing_i(xing),
    .bypass_i(bypass), .fast_any_i(fast), .slow_any_i(slow),
    .fired_vec_i(fired), .acc_any_i(acc), .veto_vec_i(veto),
    .busy_o(busy), .pass_o(pass), .reject_o(rej), .timeout_o(tmo)
  );

  // {bypass, fast, slow, exp_pass, exp_busy}
  localparam logic [4:0] VEC [6] = '{
    5'b000_00, 5'b010_10, 5'b011_10, 5'b001_01, 5'b101_10, 5'b111_10
  };

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {busy,pass,rej,tmo} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one master tick; outputs are sampled on the following falling edge
  task automatic do_tick(logic x);
    tick = 1'b1; xing = x;
    @(posedge clk); @(negedge clk);
    tick = 1'b0; xing = 1'b0;
  endtask

  task automatic idle_clk();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic open_cycle(logic [N-1:0] f);
    fired = f; slow = 1'b1; fast = 1'b0;
    do_tick(1'b1);
    slow = 1'b0;
    chk("R2 open", {busy, pass, rej, tmo}, 4'b1000);
  endtask

  task automatic close_by_acc();
    acc = 1'b1;
    for (int i = 0; i < 3; i++) do_tick(1'b0);
    acc = 1'b0;
    chk("R5 close", {busy, pass, rej, tmo}, 4'b0100);
    idle_clk();
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R10 reset", {busy, pass, rej, tmo}, 4'b0000);
    rst_n = 1'b1;
    idle_clk();
    chk("R10 after release", {busy, pass, rej, tmo}, 4'b0000);

    // start-decision table: R1 R2 R3
    fired = 4'b0011;
    foreach (VEC[k]) begin
      bypass = VEC[k][4]; fast = VEC[k][3]; slow = VEC[k][2];
      do_tick(1'b1);
      fast = 0; slow = 0; bypass = 0;
      chk($sformatf("R1/R2/R3 row %0d", k), {busy, pass, rej, tmo},
          {VEC[k][0], VEC[k][1], 2'b00});
      idle_clk();
      chk("R9 pass pulse", {1'b0, pass, rej, tmo}, 4'b0000);
      if (VEC[k][0]) close_by_acc();
    end

    // R2: no marker, no open; R11: no tick, no action
    slow = 1'b1;
    do_tick(1'b0);
    chk("R2 no marker", {busy, pass, rej, tmo}, 4'b0000);
    xing = 1'b1;
    idle_clk(); idle_clk();
    chk("R11 no tick", {busy, pass, rej, tmo}, 4'b0000);
    xing = 1'b0; slow = 1'b0;

    // R4 blind window, R8 acc beats full veto
    open_cycle(4'b0011);
    acc = 1'b1; veto = 4'b1111;
    do_tick(1'b0);
    chk("R4 blind tick1", {busy, pass, rej, tmo}, 4'b1000);
    do_tick(1'b0);
    chk("R4 blind tick2", {busy, pass, rej, tmo}, 4'b1000);
    do_tick(1'b0);
    chk("R8 acc over veto", {busy, pass, rej, tmo}, 4'b0100);
    acc = 1'b0; veto = '0;
    idle_clk();
    chk("R9 single pulse", {busy, pass, rej, tmo}, 4'b0000);

    // R6 partial veto, unfired-bit veto, then full veto
    open_cycle(4'b0011);
    veto = 4'b0101;
    for (int i = 0; i < 4; i++) do_tick(1'b0);
    chk("R6 partial veto", {busy, pass, rej, tmo}, 4'b1000);
    veto = 4'b0011;
    do_tick(1'b0);
    chk("R6 full veto", {busy, pass, rej, tmo}, 4'b0010);
    idle_clk();
    chk("R9 reject pulse", {busy, pass, rej, tmo}, 4'b0000);
    veto = '0;

    // R6 mask latched at open
    open_cycle(4'b0011);
    fired = 4'b1111;
    veto = 4'b0011;
    do_tick(1'b0); do_tick(1'b0); do_tick(1'b0);
    chk("R6 latched mask", {busy, pass, rej, tmo}, 4'b0010);
    veto = '0;

    // R5 accept with partial veto
    open_cycle(4'b0011);
    veto = 4'b0001;
    do_tick(1'b0); do_tick(1'b0);
    acc = 1'b1;
    do_tick(1'b0);
    chk("R5 accept", {busy, pass, rej, tmo}, 4'b0100);
    acc = 1'b0; veto = '0;

    // R7 timeout
    open_cycle(4'b0011);
    for (int i = 1; i < TO; i++) do_tick(1'b0);
    chk("R7 before budget", {busy, pass, rej, tmo}, 4'b1000);
    do_tick(1'b0);
    chk("R7 timeout", {busy, pass, rej, tmo}, 4'b0101);
    idle_clk();
    chk("R9 timeout pulse", {busy, pass, rej, tmo}, 4'b0000);

    // R8 verdict on final tick beats timeout
    open_cycle(4'b0011);
    for (int i = 1; i < TO; i++) do_tick(1'b0);
    acc = 1'b1;
    do_tick(1'b0);
    chk("R8 acc over timeout", {busy, pass, rej, tmo}, 4'b0100);
    acc = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule